// File: doc/BRIEF.md
# Shared SRAM Bus Hold Arbiter

This block passes ownership of an external SRAM bus between a host processor and a video capture engine. The processor asks for a new frame by pulling its flag output low. The arbiter then asserts the processor's active-low hold request and waits for the hold acknowledge. Once the processor has let go of the bus, the arbiter claims it for the capture side and raises an ownership signal. That signal also selects the pixel clock instead of the processor clock.

Capture is armed only on a fresh rising edge of the field-parity flag, so every stored frame starts at the same field. When the capture logic reports a complete frame, the arbiter does four things: it withdraws the hold request, turns its bus drivers off, pulses an active-low interrupt for a fixed number of cycles, and waits for the acknowledge to rise before it goes idle. If the processor drops its acknowledge while the capture side owns the bus, the ownership is abandoned at once and a sticky error flag is raised.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After reset: holdReqN=1, irqN=1, busOwn=0, drvEn=0, errFlag=0.
- R2: A high-to-low transition of hostFlag seen while idle drives holdReqN low exactly SYNC_STAGES+1 cycles after the flag changes. The same transition clears errFlag.
- R3: busOwn rises exactly SYNC_STAGES+1 cycles after holdAckN goes low while the request is pending. busOwn and drvEn stay low while the acknowledge has not been seen low.
- R4: drvEn (capture in progress) rises only on a rising edge of fieldPar seen while owning the bus, exactly SYNC_STAGES+1 cycles after that edge. A parity level that was already high does not start capture.
- R5: A frameDone pulse during capture releases the bus at the next clock edge: holdReqN=1, busOwn=0, drvEn=0 and irqN=0.
- R6: irqN stays low for exactly IRQ_CYCLES consecutive cycles for each completed frame (default 4).
- R7: frameDone outside capture is ignored. The interrupt does not fire and the hold and ownership outputs keep their values.
- R8: After release, the arbiter does not request the bus again while hostFlag merely stays low. A new cycle needs a new high-to-low transition after the arbiter is idle.
- R9: If holdAckN rises while the arbiter owns the bus, then exactly SYNC_STAGES+1 cycles later busOwn and drvEn are low, holdReqN is high and errFlag is 1. No interrupt is pulsed, and errFlag stays set until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostFlag | input | 1 | Processor flag; a falling transition requests a frame |
| holdAckN | input | 1 | Processor hold acknowledge, active low |
| fieldPar | input | 1 | Field-parity flag from the video decoder |
| frameDone | input | 1 | One-cycle pulse from the capture logic when a frame is stored |
| holdReqN | output | 1 | Hold request to the processor, active low |
| irqN | output | 1 | Frame-ready interrupt, active low |
| busOwn | output | 1 | Capture side owns the bus; selects the pixel clock |
| drvEn | output | 1 | Enable for the capture-side SRAM tristate drivers |
| errFlag | output | 1 | Sticky flag: the acknowledge was lost while the bus was owned |

## Verification
The bench targets the following corner cases:
- **Stale parity level.** The field-parity flag is already high when the bus is granted. A design that sampled the level instead of the edge would start capture mid-frame.
- **Flag held low after a release.** The processor keeps its flag low after a frame completes. A level-sensitive design would grab the bus again at once.
- **Stray frame-done.** A frame-done pulse arrives before capture has begun. A careless design would interrupt the processor early.
- **Acknowledge lost during capture.** The acknowledge is withdrawn while capturing. A design without the abort path would keep driving a bus the processor has reclaimed.

Every handshake latency and the interrupt width are checked cycle-exactly, so an extra or missing register stage shows up.

// File: rtl/bus_hold_arbiter_pkg.sv
package bus_hold_arbiter_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT_EDGE,
    ST_CAPTURE,
    ST_RELEASE
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic holdOn;
    logic ownOn;
    logic drvOn;
    logic irqStart;
    logic errSet;
    logic errClr;
  } arbCmd_t;

  // conditioned status from datapath to control
  typedef struct packed {
    logic flagFall;
    logic ackLow;
    logic fieldRise;
    logic irqBusy;
  } arbStat_t;

endpackage

// File: rtl/bus_hold_arbiter_sync.sv
module bus_hold_arbiter_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= {STAGES{RST_VAL}};
    else       shiftQ <= {shiftQ[STAGES-2:0], d};
  end

  assign q = shiftQ[STAGES-1];
endmodule

// File: rtl/bus_hold_arbiter_dp.sv
module bus_hold_arbiter_dp
  import bus_hold_arbiter_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_CYCLES  = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     hostFlag,
  input  logic     holdAckN,
  input  logic     fieldPar,
  input  arbCmd_t  cmd,
  output arbStat_t stat,
  output logic     holdReqN,
  output logic     irqN,
  output logic     busOwn,
  output logic     drvEn,
  output logic     errFlag
);
  localparam int CNT_W = $clog2(IRQ_CYCLES + 1);

  logic flagSync, ackSync, fieldSync;
  logic flagPrev, fieldPrev;
  logic [CNT_W-1:0] irqCnt;

  // all three asynchronous inputs share one synchroniser shape
  for (genvar g = 0; g < 3; g++) begin : gSync
    logic rawIn, syncOut;
    if (g == 0) begin : gFlag
      assign rawIn = hostFlag;
      assign flagSync = syncOut;
    end else if (g == 1) begin : gAck
      assign rawIn = holdAckN;
      assign ackSync = syncOut;
    end else begin : gField
      assign rawIn = fieldPar;
      assign fieldSync = syncOut;
    end
    bus_hold_arbiter_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL((g == 2) ? 1'b0 : 1'b1)
    ) uSync (
      .clk (clk),
      .rstN(rstN),
      .d   (rawIn),
      .q   (syncOut)
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagPrev  <= 1'b1;
      fieldPrev <= 1'b0;
    end else begin
      flagPrev  <= flagSync;
      fieldPrev <= fieldSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                irqCnt <= '0;
    else if (cmd.irqStart)    irqCnt <= CNT_W'(IRQ_CYCLES);
    else if (irqCnt != '0)    irqCnt <= irqCnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           errFlag <= 1'b0;
    else if (cmd.errSet) errFlag <= 1'b1;
    else if (cmd.errClr) errFlag <= 1'b0;
  end

  assign stat.flagFall  = flagPrev & ~flagSync;
  assign stat.ackLow    = ~ackSync;
  assign stat.fieldRise = fieldSync & ~fieldPrev;
  assign stat.irqBusy   = (irqCnt != '0);

  assign holdReqN = ~cmd.holdOn;
  assign busOwn   = cmd.ownOn;
  assign drvEn    = cmd.drvOn;
  assign irqN     = (irqCnt == '0);
endmodule

// File: rtl/bus_hold_arbiter_ctrl.sv
module bus_hold_arbiter_ctrl
  import bus_hold_arbiter_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  arbStat_t stat,
  input  logic     frameDone,
  output arbCmd_t  cmd
);
  arbState_t stateQ, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNxt;
  end

  always_comb begin
    stateNxt = stateQ;
    cmd      = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (stat.flagFall) begin
          stateNxt   = ST_REQ;
          cmd.errClr = 1'b1;
        end
      end
      ST_REQ: begin
        cmd.holdOn = 1'b1;
        if (stat.ackLow) stateNxt = ST_WAIT_EDGE;
      end
      ST_WAIT_EDGE: begin
        cmd.holdOn = 1'b1;
        cmd.ownOn  = 1'b1;
        if (!stat.ackLow) begin
          stateNxt   = ST_RELEASE;
          cmd.errSet = 1'b1;
        end else if (stat.fieldRise) begin
          stateNxt = ST_CAPTURE;
        end
      end
      ST_CAPTURE: begin
        cmd.holdOn = 1'b1;
        cmd.ownOn  = 1'b1;
        cmd.drvOn  = 1'b1;
        if (!stat.ackLow) begin
          stateNxt   = ST_RELEASE;
          cmd.errSet = 1'b1;
        end else if (frameDone) begin
          stateNxt     = ST_RELEASE;
          cmd.irqStart = 1'b1;
        end
      end
      ST_RELEASE: begin
        if (!stat.ackLow && !stat.irqBusy) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bus_hold_arbiter_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IRQ_CYCLES  = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostFlag,
  input  logic holdAckN,
  input  logic fieldPar,
  input  logic frameDone,
  output logic holdReqN,
  output logic irqN,
  output logic busOwn,
  output logic drvEn,
  output logic errFlag
);
  arbCmd_t  cmd;
  arbStat_t stat;

  bus_hold_arbiter_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .stat     (stat),
    .frameDone(frameDone),
    .cmd      (cmd)
  );

  bus_hold_arbiter_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .IRQ_CYCLES (IRQ_CYCLES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .hostFlag(hostFlag),
    .holdAckN(holdAckN),
    .fieldPar(fieldPar),
    .cmd     (cmd),
    .stat    (stat),
    .holdReqN(holdReqN),
    .irqN    (irqN),
    .busOwn  (busOwn),
    .drvEn   (drvEn),
    .errFlag (errFlag)
  );
endmodule

// File: rtl/bus_hold_arbiter_chk.sv
module bus_hold_arbiter_chk #(
  parameter int IRQ_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic hostFlag,
  input logic holdAckN,
  input logic holdReqN,
  input logic irqN,
  input logic busOwn,
  input logic drvEn
);
  logic [15:0] lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     lowRun <= '0;
    else if (!irqN) lowRun <= lowRun + 16'd1;
    else           lowRun <= '0;
  end

  AST_HOLD_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdReqN) |-> !$past(hostFlag, 2));  // R2
  AST_OWN_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busOwn |-> !holdReqN);  // R3
  AST_OWN_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOwn) |-> !$past(holdAckN, 2));  // R3
  AST_DRV_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rstN)
    drvEn |-> busOwn);  // R4
  AST_IRQ_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (holdReqN && !busOwn && !drvEn));  // R5
  AST_IRQ_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqN) |-> (lowRun == 16'(IRQ_CYCLES)));  // R6
  AST_IRQ_MAX: assert property (@(posedge clk) disable iff (!rstN)
    lowRun <= 16'(IRQ_CYCLES));  // R6
endmodule

bind bus_hold_arbiter bus_hold_arbiter_chk #(.IRQ_CYCLES(IRQ_CYCLES)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .hostFlag(hostFlag),
  .holdAckN(holdAckN),
  .holdReqN(holdReqN),
  .irqN    (irqN),
  .busOwn  (busOwn),
  .drvEn   (drvEn)
);

// File: tb/sim_bus_hold_arbiter.sv
`timescale 1ns/1ps
module sim_bus_hold_arbiter;
  localparam int SYNC = 2;
  localparam int IRQ  = 4;

  logic clk = 1'b0;
  logic rstN, hostFlag, holdAckN, fieldPar, frameDone;
  logic holdReqN, irqN, busOwn, drvEn, errFlag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bus_hold_arbiter #(.SYNC_STAGES(SYNC), .IRQ_CYCLES(IRQ)) u0 (
    .clk(clk), .rstN(rstN), .hostFlag(hostFlag), .holdAckN(holdAckN),
    .fieldPar(fieldPar), .frameDone(frameDone), .holdReqN(holdReqN),
    .irqN(irqN), .busOwn(busOwn), .drvEn(drvEn), .errFlag(errFlag)
  );

  // expected input-to-output latency: synchroniser stages plus state register
  function automatic int expLat();
    return SYNC + 1;
  endfunction

  function automatic int expIrqWidth();
    return IRQ;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  task automatic runFrame(int ackDly, int preEdge, int capLen,
                          bit abortIt, bit staleHigh, bit strayDone);
    int n;
    if (staleHigh) fieldPar = 1'b1;
    @(negedge clk);
    hostFlag = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (holdReqN && n < 20);
    chk(n == expLat(), "R2 request latency", n, expLat());
    chk(errFlag == 1'b0, "R2 error flag cleared on request", errFlag, 0);
    for (int i = 0; i < ackDly; i++) begin
      chk(!busOwn && !drvEn, "R3 no ownership before ack", busOwn, 0);
      @(negedge clk);
    end
    holdAckN = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!busOwn && n < 20);
    chk(n == expLat(), "R3 ownership latency", n, expLat());
    if (strayDone) begin
      frameDone = 1'b1;
      @(negedge clk);
      frameDone = 1'b0;
      repeat (expLat()) @(negedge clk);
      chk(irqN && !holdReqN && busOwn && !drvEn, "R7 stray frame-done ignored",
          {irqN, holdReqN, busOwn, drvEn}, 4'b1010);
    end
    if (staleHigh) begin
      repeat (6) @(negedge clk);
      chk(!drvEn, "R4 stale parity level does not arm", drvEn, 0);
      fieldPar = 1'b0;
      repeat (expLat()) @(negedge clk);
    end
    for (int i = 0; i < preEdge; i++) begin
      chk(!drvEn, "R4 waiting for parity edge", drvEn, 0);
      @(negedge clk);
    end
    fieldPar = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!drvEn && n < 20);
    chk(n == expLat(), "R4 capture latency", n, expLat());
    for (int i = 0; i < capLen; i++) begin
      chk(drvEn && busOwn && irqN, "R5 capture held until frame done", drvEn, 1);
      if ($urandom % 3 == 0) fieldPar = ~fieldPar;
      @(negedge clk);
    end
    if (!abortIt) begin
      frameDone = 1'b1;
      @(negedge clk);
      frameDone = 1'b0;
      chk(holdReqN && !busOwn && !drvEn && !irqN, "R5 release on frame done",
          {holdReqN, busOwn, drvEn, irqN}, 4'b1000);
      n = 0;
      while (!irqN && n < 50) begin n++; @(negedge clk); end
      chk(n == expIrqWidth(), "R6 interrupt width", n, expIrqWidth());
    end else begin
      holdAckN = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (drvEn && n < 20);
      chk(n == expLat(), "R9 abort latency", n, expLat());
      chk(errFlag && holdReqN && !busOwn && irqN, "R9 abort outputs",
          {errFlag, holdReqN, busOwn, irqN}, 4'b1101);
      n = 0;
      for (int i = 0; i < IRQ + 2; i++) begin
        if (!irqN) n++;
        @(negedge clk);
      end
      chk(n == 0, "R9 no interrupt on abort", n, 0);
    end
    repeat (1 + $urandom % 4) @(negedge clk);
    holdAckN = 1'b1;
    fieldPar = 1'b0;
    repeat (IRQ + expLat() + 4) @(negedge clk);
    chk(holdReqN, "R8 no re-request while flag stays low", holdReqN, 1);
    chk(errFlag == abortIt, "R9 error flag persists until next request", errFlag, abortIt);
    hostFlag = 1'b1;
    repeat (expLat() + 1) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rstN = 1'b0; hostFlag = 1'b1; holdAckN = 1'b1; fieldPar = 1'b0; frameDone = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(holdReqN && irqN && !busOwn && !drvEn && !errFlag, "R1 reset state",
        {holdReqN, irqN, busOwn, drvEn, errFlag}, 5'b11000);
    runFrame(3, 2, 10, 1'b0, 1'b0, 1'b0);
    runFrame(0, 0, 5, 1'b0, 1'b1, 1'b1);
    runFrame(2, 1, 8, 1'b1, 1'b0, 1'b0);
    runFrame(1, 3, 6, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      runFrame($urandom % 6, $urandom % 5, 1 + $urandom % 30,
               ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0);
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule